// File: doc/BRIEF.md
# Parallel RGB Display Timing Generator

This block runs in the dot-clock domain of a parallel RGB panel. It produces horizontal sync, vertical sync and data-enable for the panel. It also produces a frame-start pulse, used to swap frame buffers, and a pixel-request strobe for the FIFO that feeds the panel. All of the timing comes from programmed configuration words. Pixel formatting and memory fetch are left to neighbouring blocks.

Each line lasts a programmed number of dot clocks, and each frame lasts a programmed number of lines. The horizontal wait and the vertical wait are both measured from the leading edge of their sync pulse, so each wait includes the sync width. When a wait expires, the active window opens, for the programmed active width and active height. The sync outputs reach the panel only while a sync-enable bit is set; otherwise they rest at their inactive level. Active levels are programmable per signal, and a further bit selects the dot-clock sampling edge.

Software programs the words while `run` is low and then raises `run`. Lowering `run` returns both counters to the top-left position. The next rise starts a new frame.

Top module: `disp_timing_gen`

## Requirements
- R1: While `run` is low, the position is held at line 0, pixel 0. One clock later, hsync and vsync are at their inactive levels, the enable output is at its inactive level, and `frameStart` and `pixReq` are 0. Every output except `pixReq` is registered and shows the position of the previous clock.
- R2: Line length is `cfgLine[17:0]` dot clocks. Hsync is active for the first W clocks of every line, where W is the hsync width field.
- R3: The horizontal active window starts `cfgWait[27:16]` clocks after the hsync leading edge. It lasts `cfgActive[17:0]` clocks.
- R4: Frame length is `cfgFrameLines` lines. Vsync is active for the first `cfgTiming0[17:0]` lines of every frame.
- R5: The vertical active window starts at line `cfgWait[15:0]` and lasts `cfgActiveLines` lines. Data enable is active only when both windows are open.
- R6: Each polarity bit, when set, makes its signal active high; when clear, the signal is active low. The bits are: `cfgTiming0` bit 27 for vsync, bit 26 for hsync and bit 24 for the enable output.
- R7: When `cfgTiming0` bit 28 (enable present) is clear, the enable output stays at its inactive level while sync timing continues.
- R8: When `cfgActive` bit 18 (sync on) is clear, hsync and vsync stay at their inactive levels while the enable output keeps its timing.
- R9: `pixReq` is active high and is asserted one clock before the enable output shows the same position as active.
- R10: `frameStart` is a one-clock pulse on the first clock of vsync. It occurs exactly once per frame.
- R11: By default the hsync width field is `cfgLine[31:18]`, 14 bits. With `LEGACY_LAYOUT=1` it is `cfgLine[31:24]`, 8 bits.
- R12: `sampleFalling` follows `cfgTiming0` bit 25 with one register of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rstN | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Timing generation enable |
| cfgTiming0 | input | 32 | Polarity and enable bits; vsync width in lines |
| cfgFrameLines | input | 32 | Frame length in lines |
| cfgLine | input | 32 | Line period and hsync width field |
| cfgWait | input | 32 | Horizontal wait [27:16], vertical wait [15:0] |
| cfgActive | input | 32 | Sync-on bit 18, active width [17:0] |
| cfgActiveLines | input | 16 | Active line count |
| hsyncOut | output | 1 | Horizontal sync to the panel |
| vsyncOut | output | 1 | Vertical sync to the panel |
| deOut | output | 1 | Data enable to the panel |
| pixReq | output | 1 | Pixel request to the upstream FIFO |
| frameStart | output | 1 | Frame-start pulse |
| sampleFalling | output | 1 | Panel samples on the falling dot-clock edge |

## Verification
The bench builds two copies of the block from the same stimulus, one with the default hsync field layout and one with `LEGACY_LAYOUT=1`. Both copies use the default counter widths. A small 16-clock by 9-line frame keeps a full frame within 144 cycles. This lets every cycle of several frames be compared with a position model, including frame wrap and a restart after `run` drops. The two builds differ only in where the hsync width sits in `cfgLine`. Checking them side by side makes a decode from the wrong field show up as wrong hsync timing.

// File: rtl/tg_pkg.sv
package tg_pkg;
  // Bit positions that the decode in the top depends on
  localparam int B_EN_PRESENT = 28;
  localparam int B_VS_HIGH    = 27;
  localparam int B_HS_HIGH    = 26;
  localparam int B_FALL_EDGE  = 25;
  localparam int B_EN_HIGH    = 24;
  localparam int B_SYNC_ON    = 18;

  // Strobes from control to the position counters
  typedef struct packed {
    logic clear;
    logic lineWrap;
    logic frameWrap;
  } tgStep_t;
endpackage

// File: rtl/tg_counters.sv
module tg_counters
  import tg_pkg::*;
#(
  parameter int H_W = 18,
  parameter int V_W = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  tgStep_t        step,
  output logic [H_W-1:0] hCnt,
  output logic [V_W-1:0] vCnt
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (step.clear) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (step.lineWrap) begin
      hCnt <= '0;
      vCnt <= step.frameWrap ? '0 : vCnt + 1'b1;
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end
endmodule

// File: rtl/tg_ctrl.sv
module tg_ctrl
  import tg_pkg::*;
#(
  parameter int H_W = 18,
  parameter int V_W = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           run,
  input  logic [H_W-1:0] hCnt,
  input  logic [V_W-1:0] vCnt,
  input  logic [H_W-1:0] hPeriod,
  input  logic [H_W-1:0] hSyncW,
  input  logic [H_W-1:0] hWait,
  input  logic [H_W-1:0] hActive,
  input  logic [V_W-1:0] vPeriod,
  input  logic [V_W-1:0] vSyncW,
  input  logic [V_W-1:0] vWait,
  input  logic [V_W-1:0] vActive,
  input  logic           hsHigh,
  input  logic           vsHigh,
  input  logic           enHigh,
  input  logic           enPresent,
  input  logic           syncOn,
  input  logic           fallEdge,
  output tgStep_t        step,
  output logic           hsyncOut,
  output logic           vsyncOut,
  output logic           deOut,
  output logic           pixReq,
  output logic           frameStart,
  output logic           sampleFalling
);
  logic lineEnd, frameEnd, hWin, vWin, hSync, vSync;
  logic [H_W:0] hEndExcl;
  logic [V_W:0] vEndExcl;

  // Extra bit on every sum so that a zero or full-scale setting cannot wrap
  assign lineEnd  = ({1'b0, hCnt} + 1'b1) >= {1'b0, hPeriod};
  assign frameEnd = ({1'b0, vCnt} + 1'b1) >= {1'b0, vPeriod};
  assign hEndExcl = {1'b0, hWait} + {1'b0, hActive};
  assign vEndExcl = {1'b0, vWait} + {1'b0, vActive};
  assign hWin     = (hCnt >= hWait) && ({1'b0, hCnt} < hEndExcl);
  assign vWin     = (vCnt >= vWait) && ({1'b0, vCnt} < vEndExcl);
  assign hSync    = hCnt < hSyncW;
  assign vSync    = vCnt < vSyncW;

  always_comb begin
    step.clear     = !run;
    step.lineWrap  = lineEnd;
    step.frameWrap = lineEnd && frameEnd;
  end

  assign pixReq = run && hWin && vWin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsyncOut      <= 1'b0;
      vsyncOut      <= 1'b0;
      deOut         <= 1'b0;
      frameStart    <= 1'b0;
      sampleFalling <= 1'b0;
    end else begin
      hsyncOut      <= (run && syncOn && hSync) ? hsHigh : !hsHigh;
      vsyncOut      <= (run && syncOn && vSync) ? vsHigh : !vsHigh;
      deOut         <= (run && enPresent && hWin && vWin) ? enHigh : !enHigh;
      frameStart    <= run && (hCnt == '0) && (vCnt == '0);
      sampleFalling <= fallEdge;
    end
  end
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import tg_pkg::*;
#(
  parameter int H_W           = 18,
  parameter int V_W           = 16,
  parameter bit LEGACY_LAYOUT = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        run,
  input  logic [31:0] cfgTiming0,
  input  logic [31:0] cfgFrameLines,
  input  logic [31:0] cfgLine,
  input  logic [31:0] cfgWait,
  input  logic [31:0] cfgActive,
  input  logic [15:0] cfgActiveLines,
  output logic        hsyncOut,
  output logic        vsyncOut,
  output logic        deOut,
  output logic        pixReq,
  output logic        frameStart,
  output logic        sampleFalling
);
  tgStep_t        step;
  logic [H_W-1:0] hCnt, hPeriod, hSyncW, hWait, hActive;
  logic [V_W-1:0] vCnt, vPeriod, vSyncW, vWait, vActive;

  assign hPeriod = H_W'(cfgLine[17:0]);
  assign hWait   = H_W'(cfgWait[27:16]);
  assign hActive = H_W'(cfgActive[17:0]);
  assign vPeriod = V_W'(cfgFrameLines[15:0]);
  assign vSyncW  = V_W'(cfgTiming0[17:0]);
  assign vWait   = V_W'(cfgWait[15:0]);
  assign vActive = V_W'(cfgActiveLines);

  generate
    if (LEGACY_LAYOUT) begin : g_hsNarrow
      assign hSyncW = H_W'(cfgLine[31:24]);
    end else begin : g_hsWide
      assign hSyncW = H_W'(cfgLine[31:18]);
    end
  endgenerate

  tg_counters #(.H_W(H_W), .V_W(V_W)) u_cnt (
    .clk  (clk),
    .rstN (rstN),
    .step (step),
    .hCnt (hCnt),
    .vCnt (vCnt)
  );

  tg_ctrl #(.H_W(H_W), .V_W(V_W)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .run           (run),
    .hCnt          (hCnt),
    .vCnt          (vCnt),
    .hPeriod       (hPeriod),
    .hSyncW        (hSyncW),
    .hWait         (hWait),
    .hActive       (hActive),
    .vPeriod       (vPeriod),
    .vSyncW        (vSyncW),
    .vWait         (vWait),
    .vActive       (vActive),
    .hsHigh        (cfgTiming0[B_HS_HIGH]),
    .vsHigh        (cfgTiming0[B_VS_HIGH]),
    .enHigh        (cfgTiming0[B_EN_HIGH]),
    .enPresent     (cfgTiming0[B_EN_PRESENT]),
    .syncOn        (cfgActive[B_SYNC_ON]),
    .fallEdge      (cfgTiming0[B_FALL_EDGE]),
    .step          (step),
    .hsyncOut      (hsyncOut),
    .vsyncOut      (vsyncOut),
    .deOut         (deOut),
    .pixReq        (pixReq),
    .frameStart    (frameStart),
    .sampleFalling (sampleFalling)
  );
endmodule

// File: rtl/disp_timing_gen_chk.sv
module disp_timing_gen_chk (
  input logic        clk,
  input logic        rstN,
  input logic        run,
  input logic [31:0] cfgTiming0,
  input logic [31:0] cfgActive,
  input logic        hsyncOut,
  input logic        vsyncOut,
  input logic        deOut,
  input logic        pixReq,
  input logic        frameStart,
  input logic        sampleFalling
);
  AST_IDLE_NO_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> !frameStart); // R1

  AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart); // R10

  AST_FRAME_IN_VSYNC: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && cfgActive[18]) |-> (vsyncOut == cfgTiming0[27])); // R10

  AST_SYNC_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !cfgActive[18] |=> ((hsyncOut == !$past(cfgTiming0[26])) &&
                        (vsyncOut == !$past(cfgTiming0[27])))); // R8

  AST_REQ_LEADS_DE: assert property (@(posedge clk) disable iff (!rstN)
    (pixReq && cfgTiming0[28]) |=> (deOut == $past(cfgTiming0[24]))); // R9

  AST_NO_EN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !cfgTiming0[28] |=> (deOut == !$past(cfgTiming0[24]))); // R7

  AST_EDGE_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (sampleFalling == $past(cfgTiming0[25]))); // R12
endmodule

bind disp_timing_gen disp_timing_gen_chk u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .run           (run),
  .cfgTiming0    (cfgTiming0),
  .cfgActive     (cfgActive),
  .hsyncOut      (hsyncOut),
  .vsyncOut      (vsyncOut),
  .deOut         (deOut),
  .pixReq        (pixReq),
  .frameStart    (frameStart),
  .sampleFalling (sampleFalling)
);

// File: tb/disp_timing_gen_tb.sv
`timescale 1ns/1ps
module disp_timing_gen_tb;
  localparam int HP = 16, HSW = 3, HWT = 5, HACT = 8;
  localparam int VP = 9, VSW = 2, VWT = 3, VACT = 4;
  localparam int FRAME = HP * VP;

  logic clk = 1'b0, rstN = 1'b0, run = 1'b0;
  logic [31:0] cfgTiming0 = '0, cfgFrameLines = '0, cfgLine = '0;
  logic [31:0] cfgLineLeg = '0, cfgWait = '0, cfgActive = '0;
  logic [15:0] cfgActiveLines = '0;
  logic hsA, vsA, deA, prA, fsA, sfA;
  logic hsB, vsB, deB, prB, fsB, sfB;
  int errors = 0, checks = 0;
  bit done = 1'b0;
  bit cHsH, cVsH, cEnH, cEnP, cSync, cFall;

  always #2.5 clk = ~clk;

  disp_timing_gen u_dut (
    .clk(clk), .rstN(rstN), .run(run), .cfgTiming0(cfgTiming0),
    .cfgFrameLines(cfgFrameLines), .cfgLine(cfgLine), .cfgWait(cfgWait),
    .cfgActive(cfgActive), .cfgActiveLines(cfgActiveLines),
    .hsyncOut(hsA), .vsyncOut(vsA), .deOut(deA), .pixReq(prA),
    .frameStart(fsA), .sampleFalling(sfA));

  disp_timing_gen #(.LEGACY_LAYOUT(1'b1)) u_legacy (
    .clk(clk), .rstN(rstN), .run(run), .cfgTiming0(cfgTiming0),
    .cfgFrameLines(cfgFrameLines), .cfgLine(cfgLineLeg), .cfgWait(cfgWait),
    .cfgActive(cfgActive), .cfgActiveLines(cfgActiveLines),
    .hsyncOut(hsB), .vsyncOut(vsB), .deOut(deB), .pixReq(prB),
    .frameStart(fsB), .sampleFalling(sfB));

  task automatic compare(logic [5:0] act, logic [5:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual {hs,vs,de,req,fs,fall}=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic setCfg(bit hsH, bit vsH, bit enH, bit enP, bit syn, bit fall);
    cHsH = hsH; cVsH = vsH; cEnH = enH; cEnP = enP; cSync = syn; cFall = fall;
    cfgTiming0 = (32'(enP) << 28) | (32'(vsH) << 27) | (32'(hsH) << 26) |
                 (32'(fall) << 25) | (32'(enH) << 24) | (32'd1 << 21) |
                 (32'd1 << 20) | 32'(VSW);
    cfgFrameLines  = 32'(VP);
    cfgLine        = (32'(HSW) << 18) | 32'(HP);  // R11 wide field
    cfgLineLeg     = (32'(HSW) << 24) | 32'(HP);  // R11 narrow field
    cfgWait        = (32'(HWT) << 16) | 32'(VWT);
    cfgActive      = (32'(syn) << 18) | 32'(HACT);
    cfgActiveLines = 16'(VACT);
  endtask

  function automatic bit inWin(int p);
    int h = p % HP;
    int v = (p / HP) % VP;
    return (h >= HWT) && (h < HWT + HACT) && (v >= VWT) && (v < VWT + VACT);
  endfunction

  function automatic logic [5:0] expAt(int p);
    int h = p % HP;
    int v = (p / HP) % VP;
    logic hs, vs, de;
    hs = (cSync && h < HSW) ? cHsH : !cHsH;
    vs = (cSync && v < VSW) ? cVsH : !cVsH;
    de = (cEnP && inWin(p)) ? cEnH : !cEnH;
    return {hs, vs, de, inWin(p + 1), (p % FRAME) == 0, cFall};
  endfunction

  function automatic logic [5:0] idleVec();
    return {!cHsH, !cVsH, !cEnH, 1'b0, 1'b0, cFall};
  endfunction

  // Runs from the top-left position; after the k-th falling edge the
  // registered outputs show position k-1 and pixReq shows position k.
  task automatic scan(int cycles, string tag);
    run = 1'b1;
    for (int k = 1; k <= cycles; k++) begin
      @(negedge clk);
      compare({hsA, vsA, deA, prA, fsA, sfA}, expAt(k - 1), {tag, " main"});
      compare({hsB, vsB, deB, prB, fsB, sfB}, expAt(k - 1), {tag, " legacy R11"});
    end
    run = 1'b0;
    @(negedge clk);
    compare({hsA, vsA, deA, prA, fsA, sfA}, idleVec(), {tag, " stop R1"});
  endtask

  task automatic tReset();
    setCfg(1, 1, 1, 1, 1, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      compare({hsA, vsA, deA, prA, fsA, sfA}, idleVec(), "R1 idle after reset");
    end
  endtask

  task automatic tMain();
    setCfg(1, 1, 1, 1, 1, 0);
    @(negedge clk);
    scan(2 * FRAME + 5, "R2 R3 R4 R5 R9 R10 two frames");
  endtask

  task automatic tInverted();
    setCfg(0, 0, 0, 1, 1, 1);
    @(negedge clk);
    scan(FRAME, "R6 R12 active low");
  endtask

  task automatic tNoSync();
    setCfg(1, 0, 1, 1, 0, 0);
    @(negedge clk);
    scan(FRAME, "R8 sync off");
  endtask

  task automatic tNoEnable();
    setCfg(0, 1, 1, 0, 1, 1);
    @(negedge clk);
    scan(FRAME, "R7 enable absent");
  endtask

  task automatic tRestart();
    setCfg(1, 1, 1, 1, 1, 0);
    @(negedge clk);
    scan(60, "R1 partial frame");
    @(negedge clk);
    compare({hsA, vsA, deA, prA, fsA, sfA}, idleVec(), "R1 held idle");
    scan(FRAME + 2, "R10 restart at frame start");
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tReset();
    tMain();
    tInverted();
    tNoSync();
    tNoEnable();
    tRestart();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule